// File: doc/BRIEF.md
# First-Order Recursive Filter Section

This block computes a single-pole recursion on a stream of signed fixed-point samples: each new output is the previous output scaled by a feedback coefficient, plus the incoming sample scaled by a feedforward coefficient. Both coefficients are runtime inputs. They are held constant while a stream runs and are changed only while the block is idle or held in reset. Samples and coefficients use the signed Q1.(W-1) format, so the all-ones-but-sign code is just under +1.0 and the most negative code is exactly -1.0.

The feedforward product has no dependence on earlier results, so it is registered once. The feedback multiply, the adder and the saturation logic form one combinational path that closes into the state register in a single cycle. Because of this, each result is built on the result produced immediately before it. A static select replaces the feedback multiplier with a plain accumulator for a unity feedback coefficient.

Both stream ports use valid/ready. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high, and a result transfers where `out_valid` and `out_ready` are both high. Back-pressure stalls the whole pipeline. While a result waits unaccepted, the result stays frozen, `in_ready` is low and the registered feedforward stage holds. No sample is dropped or duplicated.

Top module: `recursive_section`

## Requirements
- R1: Each accepted sample x produces exactly one result y = sat(fb + bx). Here bx = floor(b*x / 2^(W-1)) and fb = floor(a*y_prev / 2^(W-1)), both kept at W+1 bits. y_prev is the previous result, or zero after reset. Results leave in the order the samples were accepted.
- R2: With W=16 and a = b = 16384 (0.5), the inputs 1000, 2000, 3000 give the results 500, 1250, 2125.
- R3: With `out_ready` held high, a sample accepted at clock edge k makes `out_valid` high after edge k+1 and low between edges k and k+1. Back-to-back samples are accepted one per cycle.
- R4: A sum above 2^(W-1)-1 is clamped to 2^(W-1)-1, and a sum below -2^(W-1) is clamped to -2^(W-1).
- R5: With a = b = -2^(W-1) (-1.0), the product of -1.0 and -1.0 is carried as +2^(W-1) without wrapping. For W=16 and inputs 32767, 0, -32768, the results are -32767, 32767, 1.
- R6: With `unity_a` high, y = sat(y_prev + bx), and the value on `coef_a` has no effect on any result.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_sample` holds its value, and `in_ready` is low. Every accepted sample still yields its result.
- R8: The state changes only when a sample completes the pipeline. Idle cycles between samples leave `out_sample` unchanged and do not alter later results.
- R9: A synchronous active-high `rst` drives `out_valid` low and `in_ready` high, and clears the state. The first result after reset is bx alone, even if the reset came in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| unity_a | input | 1 | Static select: 1 = accumulator feedback path, 0 = multiplied feedback |
| coef_a | input | W | Signed Q1.(W-1) feedback coefficient |
| coef_b | input | W | Signed Q1.(W-1) feedforward coefficient |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | W | Signed Q1.(W-1) input sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_sample | output | W | Signed Q1.(W-1) result |

## Verification
The hardest case to reach is a stall at the moment a sample sits in the feedforward register and another one is waiting at the input. In that case the held product must not be overwritten and the state must not advance twice. To reach it, the bench drives `out_ready` from a pseudo-random sequence while it feeds a long stream of varied samples back to back. At every stalled edge it checks that the frozen result holds, and it compares each result with a bit-exact model. The -1.0 by -1.0 corner and both saturation limits get their own directed streams, with hand-derived result values.

// File: rtl/recsec_pkg.sv
package recsec_pkg;
  typedef enum logic {
    FB_MULTIPLY   = 1'b0,
    FB_ACCUMULATE = 1'b1
  } fb_path_e;
endpackage

// File: rtl/rs_ff_stage.sv
// Registered feedforward product: b*x scaled back to Q1.(W-1), W+1 bits kept.
module rs_ff_stage #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                in_valid,
  input  logic signed [W-1:0] coef_b,
  input  logic signed [W-1:0] x,
  output logic signed [W:0]   bx_q,
  output logic                v_q
);
  localparam int P  = 2 * W;
  localparam int W1 = W + 1;

  logic signed [P-1:0] b_ext, x_ext, prod;
  logic signed [W:0]   bx_next;

  assign b_ext   = P'(coef_b);
  assign x_ext   = P'(x);
  assign prod    = b_ext * x_ext;
  assign bx_next = W1'(prod >>> (W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      bx_q <= '0;
    end else if (en) begin
      v_q <= in_valid;
      if (in_valid) bx_q <= bx_next;
    end
  end

  // R3
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (en && in_valid) |=> v_q);
endmodule

// File: rtl/rs_fb_term.sv
// Feedback term: either a*y scaled back to Q1.(W-1), or y itself for unity a.
module rs_fb_term
  import recsec_pkg::*;
#(
  parameter int W = 16
) (
  input  fb_path_e            path,
  input  logic signed [W-1:0] coef_a,
  input  logic signed [W-1:0] y,
  output logic signed [W:0]   fb
);
  localparam int P  = 2 * W;
  localparam int W1 = W + 1;

  logic signed [P-1:0] a_ext, y_ext, prod;
  logic signed [W:0]   scaled;

  assign a_ext  = P'(coef_a);
  assign y_ext  = P'(y);
  assign prod   = a_ext * y_ext;
  assign scaled = W1'(prod >>> (W - 1));

  always_comb begin
    case (path)
      FB_ACCUMULATE: fb = W1'(y);
      default:       fb = scaled;
    endcase
  end
endmodule

// File: rtl/rs_fb_update.sv
// Single-cycle loop closure: add, saturate, store; also the result valid flag.
module rs_fb_update #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                s1_v,
  input  logic signed [W:0]   fb,
  input  logic signed [W:0]   bx,
  output logic signed [W-1:0] y_q,
  output logic                out_valid
);
  localparam int S = W + 2;
  localparam logic signed [S-1:0] HI = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [S-1:0] LO = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] YMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] YMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [S-1:0] sum;
  logic signed [W-1:0] y_next;
  logic                load;

  assign sum  = S'(fb) + S'(bx);
  assign load = adv && s1_v;

  always_comb begin
    if (sum > HI)      y_next = YMAX;
    else if (sum < LO) y_next = YMIN;
    else               y_next = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q       <= '0;
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_v;
      if (s1_v) y_q <= y_next;
    end
  end

  // R8
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(y_q));

  // R3
  result_flag_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid);
endmodule

// File: rtl/recursive_section.sv
module recursive_section
  import recsec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                unity_a,
  input  logic signed [W-1:0] coef_a,
  input  logic signed [W-1:0] coef_b,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_sample
);
  logic              adv;
  logic              s1_v;
  logic signed [W:0] bx_q;
  logic signed [W:0] fb;
  fb_path_e          path;

  // Whole pipeline advances when the result slot is empty or being taken.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign path     = unity_a ? FB_ACCUMULATE : FB_MULTIPLY;

  rs_ff_stage #(.W(W)) ff_i (
    .clk(clk), .rst(rst), .en(adv), .in_valid(in_valid),
    .coef_b(coef_b), .x(in_sample), .bx_q(bx_q), .v_q(s1_v)
  );

  rs_fb_term #(.W(W)) term_i (
    .path(path), .coef_a(coef_a), .y(out_sample), .fb(fb)
  );

  rs_fb_update #(.W(W)) upd_i (
    .clk(clk), .rst(rst), .adv(adv), .s1_v(s1_v),
    .fb(fb), .bx(bx_q), .y_q(out_sample), .out_valid(out_valid)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
endmodule

// File: tb/recursive_section_tb_top.sv
module recursive_section_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic unity_a = 1'b0;
  logic signed [W-1:0] coef_a = '0, coef_b = '0, in_sample = '0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic signed [W-1:0] out_sample;

  always #2.5 clk = ~clk;

  recursive_section #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .unity_a(unity_a), .coef_a(coef_a), .coef_b(coef_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  int cap[$];
  int y_ref = 0, a_i = 0, b_i = 0;
  bit u_i = 0, bp_en = 0, stall_prev = 0;
  int held = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tmul(int c, int v);
    longint p = longint'(c) * longint'(v);
    return int'(p >>> 15);
  endfunction

  function automatic int sat(int s);
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  function automatic int ref_step(int x);
    int fbv = u_i ? y_ref : tmul(a_i, y_ref);
    y_ref = sat(fbv + tmul(b_i, x));
    return y_ref;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0];
    end else out_ready = 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev) begin
        check("R7 stall hold valid", int'(out_valid), 1);
        check("R7 stall hold data", int'(out_sample), held);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R1 unexpected result", int'(out_sample), -99999);
        else check("R1 model", int'(out_sample), exp_q.pop_front());
        cap.push_back(int'(out_sample));
      end
      stall_prev = out_valid && !out_ready;
      held = int'(out_sample);
    end else stall_prev = 0;
  end

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    y_ref = 0; exp_q.delete(); cap.delete();
  endtask

  task automatic set_coefs(int a, int b, bit u);
    coef_a = W'(a); coef_b = W'(b); unity_a = u;
    a_i = a; b_i = b; u_i = u;
  endtask

  task automatic send(int x);
    bit acc;
    in_valid = 1'b1; in_sample = W'(x);
    forever begin
      @(negedge clk) acc = in_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    exp_q.push_back(ref_step(x));
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    check("R9 out_valid in reset", int'(out_valid), 0);
    set_coefs(16384, 16384, 0);
    do_reset();
    @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;
    send(1000); send(3000); send(-2000);
    do_reset();
    send(2000); drain();
    check("R9 first result after mid-stream reset", cap[0], 1000);
  endtask

  task automatic t_known();
    set_coefs(16384, 16384, 0); do_reset();
    send(1000); send(2000); send(3000); drain();
    check("R2 y0", cap[0], 500);
    check("R2 y1", cap[1], 1250);
    check("R2 y2", cap[2], 2125);
  endtask

  task automatic t_latency();
    int c0;
    set_coefs(20000, 12000, 0); do_reset();
    send(4000);
    in_valid = 1'b0;
    @(negedge clk) check("R3 not valid after first edge", int'(out_valid), 0);
    @(negedge clk) check("R3 valid after second edge", int'(out_valid), 1);
    drain();
    c0 = cyc;
    for (int i = 0; i < 8; i++) send(i * 3000 - 9000);
    check("R3 one sample per cycle", cyc - c0, 8);
    drain();
  endtask

  task automatic t_sat();
    set_coefs(32767, 32767, 0); do_reset();
    repeat (6) send(32767);
    drain();
    check("R4 positive clamp", cap[5], 32767);
    do_reset();
    repeat (6) send(-32768);
    drain();
    check("R4 negative clamp", cap[5], -32768);
  endtask

  task automatic t_neg_one();
    set_coefs(-32768, -32768, 0); do_reset();
    send(32767); send(0); send(-32768); drain();
    check("R5 y0", cap[0], -32767);
    check("R5 y1", cap[1], 32767);
    check("R5 y2", cap[2], 1);
  endtask

  task automatic t_unity();
    set_coefs(0, 16384, 1); do_reset();
    repeat (5) send(100);
    drain();
    check("R6 accumulate a=0", cap[4], 250);
    set_coefs(-32768, 16384, 1); do_reset();
    repeat (5) send(100);
    drain();
    check("R6 accumulate a=-1", cap[4], 250);
  endtask

  task automatic t_gaps();
    int last;
    set_coefs(24576, 8192, 0); do_reset();
    for (int i = 0; i < 6; i++) begin
      send(5000 + i * 4000);
      idle(3);
    end
    drain();
    last = cap[5];
    idle(5);
    @(negedge clk);
    check("R8 idle keeps output", int'(out_sample), last);
    check("R8 idle no result", int'(out_valid), 0);
  endtask

  task automatic t_backpressure();
    set_coefs(24576, 16384, 0); do_reset();
    bp_en = 1;
    for (int i = 0; i < 20; i++) send(i * 1500 - 15000);
    drain();
    bp_en = 0;
    check("R7 all results delivered", cap.size(), 20);
    idle(2);
  endtask

  initial begin
    t_reset();
    t_known();
    t_latency();
    t_sat();
    t_neg_one();
    t_unity();
    t_gaps();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule